// File: doc/BRIEF.md
# Four-Channel DMA Programming Port and Transfer Stepper

This block is the software-facing register file of a four-channel DMA controller. It also contains the small engine that moves each channel's address and count forward. A host reaches it through a byte-wide port. The port has a 4-bit offset, a write strobe and a read strobe. Each channel has a 16-bit start address and a 16-bit transfer count. Both are reached one byte at a time. A single byte-select toggle, shared by every channel, decides whether an access touches the low or the high half. A strobe-only offset returns that toggle to the low half.

Each channel also has an 8-bit page value, written through its own strobe, which supplies the top bits of the 24-bit bus address. Each channel has a one-bit direction setting as well. The block keeps a 4-bit request mask, a command byte and four end-of-block flags.

When a channel's request line is high, its mask bit is clear and the controller is not globally disabled, the engine acknowledges the lowest-numbered such channel. It shows that channel's full address, then steps the address up and the count down. The count holds the number of transfers minus one. When it passes below zero, the engine raises a terminal-count pulse, latches the channel's flag and masks the channel.

Top module: `dmac_regif`

## Requirements
- R1: After reset, or on any write to offset 0xD, all four mask bits read 1. The byte select points to the low byte. Flags, command, addresses, counts, pages and directions are all 0.
- R2: Offset 2n reaches channel n's address and offset 2n+1 reaches its count, for n = 0..3. Each read or write strobe at offsets 0x0..0x7 handles the byte chosen by the shared select (low first) and then toggles the select. A read returns that byte.
- R3: Any write to offset 0xC returns the byte select to the low byte, whatever the data.
- R4: A write to 0xA sets or clears one mask bit: data bits 1:0 pick the channel and bit 2 is the new value. A write to 0xF loads all four mask bits from data bits 3:0. A read of 0xF returns the mask in bits 3:0 with zeros above. A write to 0xE clears every mask bit.
- R5: A write to 0xB sets the direction of the channel picked by data bits 1:0 to data bit 2 (1 = write to memory). `xfer_dir` shows the direction of the acknowledged channel.
- R6: A `page_wr` strobe loads `wdata` into the page of the channel given by `port_addr[1:0]`. It leaves the byte select unchanged. `xfer_addr[23:16]` is the acknowledged channel's page.
- R7: `dack` is one-hot or zero. It acknowledges the lowest-numbered channel whose request is high and whose mask bit is clear. Nothing is acknowledged while command bit 2 is set, or in any cycle with `wr_en` or `page_wr` high. A write to 0x8 stores the command byte.
- R8: Each acknowledged cycle presents {page, address} on `xfer_addr`. At the next edge the address grows by 1 (16-bit wrap, page unchanged) and the count falls by 1.
- R9: An acknowledged cycle with count 0 drives `tc` high in that cycle. The count wraps to 0xFFFF, and the channel's flag and mask bit are set, so a stored count N gives N+1 transfers.
- R10: A read of 0x8 returns the flags in bits 3:0 (bit n = channel n) and the live request lines in bits 7:4. The read clears the flags, but a flag set in the same cycle survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| port_addr | input | 4 | Register offset; bits 1:0 also pick the channel for page writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| page_wr | input | 1 | Page register write strobe |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge |
| tc | output | 1 | Terminal-count pulse of the acknowledged channel |
| xfer_dir | output | 1 | Direction of the acknowledged channel |
| xfer_addr | output | 24 | Page and address of the acknowledged channel |

## Verification
The transfer engine is driven in three ways, and each one separates a different class of fault:
- A single channel requests for a whole block. This shows whether the address steps up, the count steps down and terminal count lands on the right beat.
- Two channels request together while mask bits, the global disable and register writes are toggled. This shows the priority order and every blocking condition.
- Byte loads are interleaved with pointer-clear writes, page writes and a master clear. This shows that only the intended strobes move the shared byte select.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned BYTE_W = 8;

    localparam logic [3:0] OFS_CMD      = 4'h8;
    localparam logic [3:0] OFS_ONE_MASK = 4'hA;
    localparam logic [3:0] OFS_DIR      = 4'hB;
    localparam logic [3:0] OFS_PTR_CLR  = 4'hC;
    localparam logic [3:0] OFS_RESET    = 4'hD;
    localparam logic [3:0] OFS_UNMASK   = 4'hE;
    localparam logic [3:0] OFS_ALL_MASK = 4'hF;

    localparam int unsigned CMD_STOP_BIT = 2;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic              hi_sel,
    input  logic              ld_dir,
    input  logic              dir_in,
    input  logic              ld_page,
    input  logic [BYTE_W-1:0] din,
    input  logic              step,
    output logic [REG_W-1:0]  addr,
    output logic [REG_W-1:0]  cnt,
    output logic [PAGE_W-1:0] page,
    output logic              dir
);
    typedef struct packed {
        logic [REG_W-1:0]  addr;
        logic [REG_W-1:0]  cnt;
        logic [PAGE_W-1:0] page;
        logic              dir;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (step) begin
                st_d.addr = st_q.addr + 1'b1;
                st_d.cnt  = st_q.cnt - 1'b1;
            end
            if (ld_addr) begin
                if (hi_sel) st_d.addr[REG_W-1:BYTE_W] = din;
                else        st_d.addr[BYTE_W-1:0]     = din;
            end
            if (ld_cnt) begin
                if (hi_sel) st_d.cnt[REG_W-1:BYTE_W] = din;
                else        st_d.cnt[BYTE_W-1:0]     = din;
            end
            if (ld_dir)  st_d.dir  = dir_in;
            if (ld_page) st_d.page = PAGE_W'(din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;
    assign cnt  = st_q.cnt;
    assign page = st_q.page;
    assign dir  = st_q.dir;

    // R8: a plain acknowledged beat moves address up and count down by one
    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !ld_addr && !ld_cnt) |=>
            (addr == REG_W'($past(addr) + 1'b1)) && (cnt == REG_W'($past(cnt) - 1'b1)));
endmodule

// File: rtl/dmac_pick.sv
module dmac_pick #(
    parameter int CH = 4
) (
    input  logic [CH-1:0] req,
    output logic [CH-1:0] grant
);
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < CH; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dmac_regif.sv
module dmac_regif
    import dmac_pkg::*;
#(
    parameter int CH     = 4,
    parameter int PAGE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [3:0]              port_addr,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [BYTE_W-1:0]       rdata,
    input  logic                    page_wr,
    input  logic [CH-1:0]           dreq,
    output logic [CH-1:0]           dack,
    output logic                    tc,
    output logic                    xfer_dir,
    output logic [PAGE_W+REG_W-1:0] xfer_addr
);
    localparam int CW = $clog2(CH);

    typedef struct packed {
        logic [CH-1:0]     mask;
        logic [CH-1:0]     flags;
        logic [BYTE_W-1:0] cmd;
        logic              ptr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [REG_W-1:0]  ch_addr [CH];
    logic [REG_W-1:0]  ch_cnt  [CH];
    logic [PAGE_W-1:0] ch_page [CH];
    logic [CH-1:0]     ch_dir;
    logic [CH-1:0]     ld_addr, ld_cnt, ld_dir, ld_page;
    logic [CH-1:0]     req_ok, grant, tc_vec;

    logic          is_chreg, wr_any, mclr;
    logic [CW-1:0] reg_ch;

    assign is_chreg = (port_addr[3] == 1'b0);
    assign reg_ch   = port_addr[CW:1];
    assign wr_any   = wr_en | page_wr;
    assign mclr     = wr_en && (port_addr == OFS_RESET);
    assign req_ok   = dreq & ~ctl_q.mask & {CH{~ctl_q.cmd[CMD_STOP_BIT] & ~wr_any}};

    dmac_pick #(.CH(CH)) i_pick (.req(req_ok), .grant(grant));

    // per-channel load strobes and acknowledge outputs
    always_comb begin
        tc_vec    = '0;
        xfer_addr = '0;
        xfer_dir  = 1'b0;
        for (int i = 0; i < CH; i++) begin
            ld_addr[i] = wr_en && is_chreg && (reg_ch == CW'(i)) && !port_addr[0];
            ld_cnt[i]  = wr_en && is_chreg && (reg_ch == CW'(i)) &&  port_addr[0];
            ld_dir[i]  = wr_en && (port_addr == OFS_DIR) && (wdata[CW-1:0] == CW'(i));
            ld_page[i] = page_wr && (port_addr[CW-1:0] == CW'(i));
            tc_vec[i]  = grant[i] && (ch_cnt[i] == '0);
            if (grant[i]) begin
                xfer_addr = {ch_page[i], ch_addr[i]};
                xfer_dir  = ch_dir[i];
            end
        end
    end

    assign dack = grant;
    assign tc   = |tc_vec;

    for (genvar g = 0; g < CH; g++) begin : g_chan
        dmac_chan #(.PAGE_W(PAGE_W)) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (mclr),
            .ld_addr (ld_addr[g]),
            .ld_cnt  (ld_cnt[g]),
            .hi_sel  (ctl_q.ptr),
            .ld_dir  (ld_dir[g]),
            .dir_in  (wdata[2]),
            .ld_page (ld_page[g]),
            .din     (wdata),
            .step    (grant[g]),
            .addr    (ch_addr[g]),
            .cnt     (ch_cnt[g]),
            .page    (ch_page[g]),
            .dir     (ch_dir[g])
        );
    end

    // control state next value
    always_comb begin
        ctl_d = ctl_q;
        if ((wr_en || rd_en) && is_chreg) ctl_d.ptr = ~ctl_q.ptr;
        if (rd_en && port_addr == OFS_CMD) ctl_d.flags = '0;
        if (wr_en) begin
            case (port_addr)
                OFS_CMD:      ctl_d.cmd = wdata;
                OFS_ONE_MASK: ctl_d.mask[wdata[CW-1:0]] = wdata[2];
                OFS_PTR_CLR:  ctl_d.ptr = 1'b0;
                OFS_UNMASK:   ctl_d.mask = '0;
                OFS_ALL_MASK: ctl_d.mask = wdata[CH-1:0];
                default: ;
            endcase
        end
        ctl_d.flags = ctl_d.flags | tc_vec;
        ctl_d.mask  = ctl_d.mask | tc_vec;
        if (mclr) begin
            ctl_d      = '0;
            ctl_d.mask = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // read data
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (is_chreg) begin
                if (port_addr[0]) rdata = ctl_q.ptr ? ch_cnt[reg_ch][REG_W-1:BYTE_W]  : ch_cnt[reg_ch][BYTE_W-1:0];
                else              rdata = ctl_q.ptr ? ch_addr[reg_ch][REG_W-1:BYTE_W] : ch_addr[reg_ch][BYTE_W-1:0];
            end else if (port_addr == OFS_CMD) begin
                rdata = BYTE_W'({dreq, ctl_q.flags});
            end else if (port_addr == OFS_ALL_MASK) begin
                rdata = BYTE_W'(ctl_q.mask);
            end
        end
    end

    // R7: at most one acknowledge, never to a masked channel, none when stopped
    p_dack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dack));
    p_dack_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n) (dack & ctl_q.mask) == '0);
    p_dack_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cmd[CMD_STOP_BIT] |-> (dack == '0));
    // R3: pointer-clear write leaves the select on the low byte
    p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_addr == OFS_PTR_CLR) |=> !ctl_q.ptr);
    // R9: the channel reaching terminal count masks itself
    p_tc_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> ((ctl_q.mask & $past(dack)) == $past(dack)) && ((ctl_q.flags & $past(dack)) == $past(dack)));
    // R1: master clear state
    p_master_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (ctl_q.mask == '1) && (ctl_q.flags == '0) && !ctl_q.ptr && (ctl_q.cmd == '0));
endmodule

// File: tb/test_dmac_regif.sv
module test_dmac_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, page_wr = 1'b0;
    logic [3:0]  port_addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic        tc, xfer_dir;
    logic [23:0] xfer_addr;

    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    dmac_regif i_dmac_regif (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .port_addr(port_addr), .wdata(wdata), .rdata(rdata), .page_wr(page_wr),
        .dreq(dreq), .dack(dack), .tc(tc), .xfer_dir(xfer_dir), .xfer_addr(xfer_addr)
    );

    // observed vector: rdata[37:30] dack[29:26] tc[25] dir[24] addr[23:0]
    typedef struct {
        string       tag;
        logic [37:0] act;
        logic [37:0] exp;
        logic [37:0] care;
    } item_t;

    item_t sbq[$];

    localparam logic [37:0] C_RD   = {8'hFF, 30'h0};
    localparam logic [37:0] C_XFER = {8'h00, 4'hF, 1'b1, 1'b1, 24'hFFFFFF};
    localparam logic [37:0] C_DACK = {8'h00, 4'hF, 26'h0};

    function automatic logic [37:0] observe();
        return {rdata, dack, tc, xfer_dir, xfer_addr};
    endfunction

    task automatic drain();
        while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            n_run++;
            if ((it.act & it.care) !== (it.exp & it.care)) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, it.act & it.care, it.exp & it.care);
            end
        end
    endtask

    always @(negedge clk) drain();

    task automatic push(string tag, logic [37:0] exp, logic [37:0] care);
        item_t it;
        it.tag = tag; it.act = observe(); it.exp = exp; it.care = care;
        sbq.push_back(it);
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        wr_en = 1'b1; port_addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_chk_dack(string tag, logic [3:0] a, logic [7:0] d);
        wr_en = 1'b1; port_addr = a; wdata = d;
        #2 push(tag, '0, C_DACK);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pg(logic [1:0] ch, logic [7:0] d);
        page_wr = 1'b1; port_addr = {2'b00, ch}; wdata = d;
        @(negedge clk);
        page_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic [3:0] a, logic [7:0] e);
        rd_en = 1'b1; port_addr = a;
        #2 push(tag, {e, 30'h0}, C_RD);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic xfer(string tag, logic [3:0] ed, logic et, logic edir, logic [23:0] ea);
        #2 push(tag, {8'h00, ed, et, edir, ea}, (ed == 4'h0) ? {8'h00, 4'hF, 1'b1, 25'h0} : C_XFER);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung, expected finished run");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1 mask after reset", 4'hF, 8'h0F);
        rd("R1 flags after reset", 4'h8, 8'h00);

        // program channel 1: addr 1234, count 2, page 56, write-to-memory
        wr(4'hC, 8'h00);
        wr(4'h2, 8'h34); wr(4'h2, 8'h12);
        pg(2'd1, 8'h56);
        wr(4'h3, 8'h02); wr(4'h3, 8'h00);
        wr(4'hB, 8'h05);
        wr(4'hA, 8'h01);
        rd("R4 single-channel unmask", 4'hF, 8'h0D);

        dreq = 4'b0010;
        xfer("R7 R5 first beat ch1", 4'b0010, 1'b0, 1'b1, 24'h561234);
        xfer("R8 second beat ch1", 4'b0010, 1'b0, 1'b1, 24'h561235);
        xfer("R9 tc on third beat", 4'b0010, 1'b1, 1'b1, 24'h561236);
        xfer("R9 channel masked after tc", 4'b0000, 1'b0, 1'b0, 24'h0);
        rd("R10 flags with live request", 4'h8, 8'h22);
        rd("R10 flags cleared by read", 4'h8, 8'h20);
        dreq = 4'b0000;

        wr(4'hC, 8'h00);
        rd("R8 R2 address low after block", 4'h2, 8'h37);
        rd("R8 R2 address high after block", 4'h2, 8'h12);
        rd("R9 count low wrapped", 4'h3, 8'hFF);
        rd("R9 count high wrapped", 4'h3, 8'hFF);

        // R3: pointer clear mid-load, data ignored
        wr(4'hC, 8'h00);
        wr(4'h0, 8'hAA);
        wr(4'hC, 8'hFF);
        wr(4'h0, 8'hBB); wr(4'h0, 8'hCC);
        wr(4'hC, 8'h00);
        rd("R3 low byte after pointer clear", 4'h0, 8'hBB);
        rd("R3 high byte after pointer clear", 4'h0, 8'hCC);

        // R6: page write does not move the byte select
        wr(4'hC, 8'h00);
        wr(4'h4, 8'h11);
        pg(2'd2, 8'h9A);
        wr(4'h4, 8'h22);
        wr(4'hC, 8'h00);
        rd("R6 ch2 low byte", 4'h4, 8'h11);
        rd("R6 ch2 high byte", 4'h4, 8'h22);

        // priority and blocking
        wr(4'h1, 8'h05); wr(4'h1, 8'h00);
        wr(4'h5, 8'h05); wr(4'h5, 8'h00);
        wr(4'hF, 8'h0A);
        rd("R4 full mask read", 4'hF, 8'h0A);
        dreq = 4'b0101;
        xfer("R7 lowest channel wins", 4'b0001, 1'b0, 1'b0, 24'h00CCBB);
        wr_chk_dack("R7 no ack during write", 4'hA, 8'h04);
        xfer("R7 masked ch0 yields to ch2", 4'b0100, 1'b0, 1'b0, 24'h9A2211);
        wr(4'h8, 8'h04);
        xfer("R7 command stop bit", 4'b0000, 1'b0, 1'b0, 24'h0);
        wr(4'h8, 8'h00);
        xfer("R8 ch2 resumes", 4'b0100, 1'b0, 1'b0, 24'h9A2212);
        wr(4'hB, 8'h06);
        xfer("R5 ch2 direction set", 4'b0100, 1'b0, 1'b1, 24'h9A2213);
        dreq = 4'b0000;

        // R4 clear-all and single set
        wr(4'hE, 8'h00);
        rd("R4 clear all mask", 4'hF, 8'h00);
        wr(4'hA, 8'h07);
        rd("R4 single-channel set", 4'hF, 8'h08);

        // R1 master clear
        wr(4'h0, 8'h77);
        wr(4'hD, 8'h00);
        rd("R1 mask after master clear", 4'hF, 8'h0F);
        rd("R1 flags after master clear", 4'h8, 8'h00);
        wr(4'hC, 8'h00);
        rd("R1 ch1 address cleared", 4'h2, 8'h00);
        wr(4'hD, 8'h00);
        wr(4'h0, 8'h5A); wr(4'h0, 8'hA5);
        wr(4'hC, 8'h00);
        rd("R1 byte select low after master clear", 4'h0, 8'h5A);

        @(negedge clk);
        drain();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule